// File: doc/BRIEF.md
# Interleaved Low-Activity Shift Register

This block is a serial delay line of DEPTH stages, 16 by default. It delivers one bit per cycle of the full-rate clock, but each storage flip-flop updates on only one cycle in every LANES cycles. The incoming stream is dealt round-robin into LANES banks of DEPTH/LANES stages each. A modulo-LANES phase counter picks the bank that captures the current input bit. Only that bank advances on the edge, and the others hold their contents.

The same phase value drives an output multiplexer. It selects the bank whose oldest bit is due, so the serial output matches a plain single-chain shifter of DEPTH stages bit for bit, with the same latency. LANES may be 1, 2 or 4. The storage update activity, and with it the switching power of the storage, falls to 1.0, 0.5 or 0.25 of the single-chain figure.

The per-bank update strobes are brought out as a port. A surrounding design or a bench can use them to confirm the reduced activity.

Top module: `interleaved_shifter`

## Requirements
- R1: With the default LANES of 2, the output after clock edge e equals the input sampled at edge e-(DEPTH-1), counting edges from the first edge after reset is released. Before enough edges have passed, the output is 0.
- R2: Input bits are distributed round-robin. The bit sampled at the k-th edge after reset enters stage 0 of bank (k mod LANES), and a single isolated 1 in the stream therefore appears exactly once at the output, DEPTH-1 edges later.
- R3: The phase counter steps 0, 1, ..., LANES-1 and then wraps to 0, advancing on every edge. Bit b of bank_en is 1 exactly when the phase equals b, so bank_en is always one-hot.
- R4: A bank changes only on an edge where its enable bit is 1. Over any run of edges that is a multiple of LANES and starts at reset, each enable bit is 1 on exactly 1/LANES of the edges.
- R5: Synchronous active-high reset clears every bank and sets the phase to 0. While reset is applied, dout is 0 and bank_en has only bit 0 set. After a reset in mid-stream, the output is 0 until newly shifted bits arrive.
- R6: With LANES = 1, the block is a single chain that updates on every edge. bank_en is then constantly 1, and the output follows the R1 timing.
- R7: With LANES = 4, four banks of DEPTH/4 stages rebuild the same output stream with the R1 timing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Full-rate serial clock |
| rst | input | 1 | Synchronous reset, active high |
| din | input | 1 | Serial data in, sampled on every rising edge |
| dout | output | 1 | Serial data out, delayed by DEPTH-1 edges |
| bank_en | output | LANES | One-hot update strobe, one bit per bank |

## Verification
The bench drives din after each falling edge and samples dout and bank_en at the next falling edge. Both outputs therefore reflect the edge that has just occurred. A bit driven before edge e is expected on dout in the sample taken after edge e+DEPTH-1. bank_en is expected to show phase (number of edges since reset) mod LANES in the same sample. The bench keeps its own plain DEPTH-bit shift model and its own edge count, both advanced once per edge. Each output is compared with these in the same half cycle.

// File: rtl/ihs_pkg.sv
package ihs_pkg;

  // Phase value that follows ph in a modulo-lanes rotation.
  function automatic int unsigned phase_after(input int unsigned ph, input int unsigned lanes);
    return (ph + 1 >= lanes) ? 0 : ph + 1;
  endfunction

  // Number of stages each bank holds.
  function automatic int unsigned stages_per_bank(input int unsigned depth, input int unsigned lanes);
    return depth / lanes;
  endfunction

  // Width of the phase counter (at least one bit).
  function automatic int unsigned phase_width(input int unsigned lanes);
    return (lanes > 1) ? $clog2(lanes) : 1;
  endfunction

endpackage

// File: rtl/ihs_phase_gen.sv
module ihs_phase_gen #(
  parameter int LANES = 2,
  parameter int PW    = 1
) (
  input  logic             clk,
  input  logic             rst,
  output logic [PW-1:0]    phase,
  output logic [LANES-1:0] bank_en
);

  always_ff @(posedge clk) begin
    if (rst) phase <= '0;
    else     phase <= PW'(ihs_pkg::phase_after(int'(phase), LANES));
  end

  for (genvar b = 0; b < LANES; b++) begin : g_dec
    assign bank_en[b] = (phase == PW'(b));
  end

  AST_PHASE_WRAP: assert property (@(posedge clk) disable iff (rst)
    (phase == PW'(LANES-1)) |=> (phase == '0)); // R3

endmodule

// File: rtl/ihs_bank.sv
module ihs_bank #(
  parameter int STAGES = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic din,
  output logic top
);

  logic [STAGES-1:0] stg;

  if (STAGES > 1) begin : g_chain
    always_ff @(posedge clk) begin
      if (rst)     stg <= '0;
      else if (en) stg <= {stg[STAGES-2:0], din};
    end
  end else begin : g_single
    always_ff @(posedge clk) begin
      if (rst)     stg <= '0;
      else if (en) stg <= din;
    end
  end

  assign top = stg[STAGES-1];

  AST_BANK_HOLD: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(stg)); // R4

  AST_BANK_LOAD: assert property (@(posedge clk) disable iff (rst)
    en |=> (stg[0] == $past(din))); // R2

  AST_BANK_CLEAR: assert property (@(posedge clk)
    rst |=> (stg == '0)); // R5

endmodule

// File: rtl/ihs_out_mux.sv
module ihs_out_mux #(
  parameter int LANES = 2,
  parameter int PW    = 1
) (
  input  logic [LANES-1:0] tops,
  input  logic [PW-1:0]    sel,
  output logic             dout
);

  if (LANES == 1) begin : g_pass
    assign dout = tops[0];
  end else begin : g_rot
    assign dout = tops[sel];
  end

endmodule

// File: rtl/interleaved_shifter.sv
module interleaved_shifter #(
  parameter int DEPTH = 16,
  parameter int LANES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             din,
  output logic             dout,
  output logic [LANES-1:0] bank_en
);

  localparam int STAGES = int'(ihs_pkg::stages_per_bank(DEPTH, LANES));
  localparam int PW     = int'(ihs_pkg::phase_width(LANES));

  logic [PW-1:0]    phase;
  logic [LANES-1:0] tops;

  ihs_phase_gen #(.LANES(LANES), .PW(PW)) u_phase (
    .clk     (clk),
    .rst     (rst),
    .phase   (phase),
    .bank_en (bank_en)
  );

  for (genvar b = 0; b < LANES; b++) begin : g_bank
    ihs_bank #(.STAGES(STAGES)) u_bank (
      .clk (clk),
      .rst (rst),
      .en  (bank_en[b]),
      .din (din),
      .top (tops[b])
    );
  end

  ihs_out_mux #(.LANES(LANES), .PW(PW)) u_mux (
    .tops (tops),
    .sel  (phase),
    .dout (dout)
  );

  AST_EN_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $countones(bank_en) == 1); // R3

  AST_EN_ROTATES: assert property (@(posedge clk) disable iff (rst)
    bank_en[LANES-1] |=> bank_en[0]); // R3

  AST_RESET_OUT: assert property (@(posedge clk)
    rst |=> (dout == 1'b0)); // R5

endmodule

// File: tb/interleaved_shifter_tb.sv
module interleaved_shifter_tb;

  localparam int DEPTH = 16;
  localparam int NPAT  = 6;
  localparam logic [31:0] PATS [NPAT] = '{
    32'hFFFF0000, 32'hAAAAAAAA, 32'h0F0F3C3C,
    32'hDEADBEEF, 32'hC3A50081, 32'h00000000
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic din = 1'b0;
  logic dout2, dout1, dout4;
  logic [1:0] en2;
  logic [0:0] en1;
  logic [3:0] en4;

  always #10 clk = ~clk;

  interleaved_shifter #(.DEPTH(DEPTH), .LANES(2)) u_dut (
    .clk(clk), .rst(rst), .din(din), .dout(dout2), .bank_en(en2));
  interleaved_shifter #(.DEPTH(DEPTH), .LANES(1)) u_dut_n1 (
    .clk(clk), .rst(rst), .din(din), .dout(dout1), .bank_en(en1));
  interleaved_shifter #(.DEPTH(DEPTH), .LANES(4)) u_dut_n4 (
    .clk(clk), .rst(rst), .din(din), .dout(dout4), .bank_en(en4));

  int total = 0;
  int fails = 0;
  int edges = 0;
  int cnt2 [2];
  int cnt4 [4];
  logic [DEPTH-1:0] model = '0;

  task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h (edge %0d)", req, act, exp, edges);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  endtask

  // One full-rate cycle: drive, let an edge pass, compare at the falling edge.
  task automatic step(input logic b, input string tag);
    din = b;
    @(posedge clk);
    model = {model[DEPTH-2:0], b};
    edges++;
    @(negedge clk);
    check({tag, " n2 dout"}, {3'b0, dout2}, {3'b0, model[DEPTH-1]});
    check("R6 n1 dout", {3'b0, dout1}, {3'b0, model[DEPTH-1]});
    check("R7 n4 dout", {3'b0, dout4}, {3'b0, model[DEPTH-1]});
    check("R3 n2 bank_en", {2'b0, en2}, 4'(1 << (edges % 2)));
    check("R6 n1 bank_en", {3'b0, en1}, 4'b0001);
    check("R3 n4 bank_en", en4, 4'(1 << (edges % 4)));
    for (int i = 0; i < 2; i++) cnt2[i] += int'(en2[i]);
    for (int i = 0; i < 4; i++) cnt4[i] += int'(en4[i]);
  endtask

  task automatic apply_reset();
    @(negedge clk);
    rst = 1'b1;
    din = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R5 reset dout n2", {3'b0, dout2}, 4'b0);
    check("R5 reset dout n1", {3'b0, dout1}, 4'b0);
    check("R5 reset dout n4", {3'b0, dout4}, 4'b0);
    check("R5 reset bank_en n2", {2'b0, en2}, 4'b0001);
    check("R5 reset bank_en n4", en4, 4'b0001);
    rst = 1'b0;
    model = '0;
    edges = 0;
    for (int i = 0; i < 2; i++) cnt2[i] = 0;
    for (int i = 0; i < 4; i++) cnt4[i] = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    apply_reset();

    // Table of stimulus words, MSB first; expected stream from the model.
    for (int p = 0; p < NPAT; p++)
      for (int i = 31; i >= 0; i--)
        step(PATS[p][i], "R1");

    // Activity: 192 edges since reset, a multiple of 2 and 4.
    for (int i = 0; i < 2; i++) check("R4 n2 update share", 4'(cnt2[i] == edges / 2), 4'd1);
    for (int i = 0; i < 4; i++) check("R4 n4 update share", 4'(cnt4[i] == edges / 4), 4'd1);

    // Isolated ones at every phase offset.
    apply_reset();
    for (int off = 0; off < 4; off++) begin
      for (int i = 0; i < off; i++) step(1'b0, "R2");
      step(1'b1, "R2");
      for (int i = 0; i < DEPTH + 3; i++) step(1'b0, "R2");
    end

    // Mid-stream reset with full banks, then zeros must come out.
    for (int i = 0; i < 21; i++) step(1'b1, "R1");
    apply_reset();
    for (int i = 0; i < DEPTH; i++) step(1'b0, "R5");
    for (int i = 0; i < 2 * DEPTH; i++) step(1'(i % 3 == 0), "R1");

    finish_run();
  end

endmodule